// File: doc/BRIEF.md
# Eight-Bit Add/Subtract Unit with Status Flags

This block performs an 8-bit addition or subtraction on two operands and keeps a registered status byte. The status byte holds a carry/borrow flag, a nibble half-carry/borrow flag, a signed overflow flag and a parity flag. The other status bits are plain storage. The arithmetic result is combinational. The carry, half-carry and overflow flags are captured on a clock edge only when the flag update enable is high.

The incoming carry comes from the `cy_in` port. It takes part only when `use_cin` is set: as a carry for an addition, or as a borrow for a subtraction. The parity flag does not depend on the arithmetic. It follows the accumulator value written through `acc_we`/`acc_val`. Software-style writes through `stat_we` can load every status bit except parity, which always reflects the accumulator.

Top module: `alu_status_unit`

## Requirements
- R1: `result` equals (op_a + op_b + cin) mod 256 when `op_sub`=0, and (op_a − op_b − cin) mod 256 when `op_sub`=1. Here cin = `use_cin` & `cy_in`.
- R2: After a clock edge with `flag_upd`=1, status bit 7 is 1 in two cases: an addition produced a carry out of bit 7, or a subtraction needed a borrow into bit 7. Otherwise it is 0.
- R3: After a clock edge with `flag_upd`=1, status bit 6 is 1 in two cases: the low nibble carried into bit 4 on addition, or the low nibble borrowed from bit 4 on subtraction. Otherwise it is 0.
- R4: After a clock edge with `flag_upd`=1, status bit 2 is 1 exactly when the signed two's-complement result falls outside −128..127.
- R5: After a clock edge with `acc_we`=1, status bit 0 is 1 when `acc_val` has an odd number of 1 bits. It is 0 when the count is even; for example, 0xCC gives 0.
- R6: Status bits 7, 6 and 2 hold their value across any edge where both `flag_upd` and `stat_we` are 0. This holds whatever the operands are.
- R7: When `use_cin`=0, `cy_in` has no effect on `result` or on the captured flags.
- R8: A clock edge with `stat_we`=1 loads status bits 7..1 from `stat_wdata[7:1]`. `stat_wdata[0]` is ignored. When `flag_upd` is also 1, the arithmetic flags take priority for bits 7, 6 and 2.
- R9: A clock edge with `rst_n`=0 clears the whole status byte to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| use_cin | input | 1 | Include `cy_in` as carry or borrow |
| cy_in | input | 1 | Incoming carry/borrow value |
| flag_upd | input | 1 | Capture carry, half-carry and overflow |
| acc_we | input | 1 | Accumulator write strobe (updates parity) |
| acc_val | input | 8 | New accumulator value |
| stat_we | input | 1 | Direct write of status bits 7..1 |
| stat_wdata | input | 8 | Data for direct status write |
| result | output | 8 | Combinational arithmetic result |
| status | output | 8 | Registered status byte |

## Verification
The arithmetic is driven with operands chosen to isolate each flag. One pair carries only out of the low nibble, one overflows only into the sign bit, and one wraps past 0xFF with no signed overflow. The subtraction counterparts do the same with borrows. A sweep of further operand pairs, with the incoming carry both masked and enabled, separates the carry-in and borrow-in paths. Accumulator values of even and odd weight tell the parity tracking apart from the arithmetic. Edges with updates disabled, direct writes with and without a concurrent update, and a mid-run reset show the hold, priority and clear behaviour.

// File: rtl/alu_status_pkg.sv
// Shared definitions for the add/subtract status unit.
// Assumes an 8-bit status byte; bit positions are fixed by the register layout.
package alu_status_pkg;
    localparam int STAT_W  = 8;
    localparam int BIT_CY  = 7;
    localparam int BIT_HC  = 6;
    localparam int BIT_OV  = 2;
    localparam int BIT_PAR = 0;

    typedef struct packed {
        logic cy;
        logic hc;
        logic ov;
    } arith_flags_t;
endpackage

// File: rtl/addsub_core.sv
// Combinational W-bit adder/subtractor producing the result and the
// carry/borrow, nibble half-carry/borrow and signed overflow flags.
// Assumes W > NIB >= 1. Subtraction is done as a + ~b + ~borrow.
module addsub_core
    import alu_status_pkg::*;
#(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          sub,
    input  logic          cin,
    output logic [W-1:0]  sum,
    output arith_flags_t  flags
);
    logic [W-1:0]   b_eff;
    logic           c_eff;
    logic [NIB:0]   lo_sum;
    logic [W-1:0]   mid_sum;
    logic [W:0]     full_sum;

    // Form the inverted operand and carry for subtraction, then the partial sums.
    always_comb begin
        b_eff    = sub ? ~b : b;
        c_eff    = sub ? ~cin : cin;
        lo_sum   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
        mid_sum  = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, c_eff};
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    end

    // Derive result and flags; borrow is the inverse of the internal carry.
    always_comb begin
        sum      = full_sum[W-1:0];
        flags.cy = full_sum[W] ^ sub;
        flags.hc = lo_sum[NIB] ^ sub;
        flags.ov = mid_sum[W-1] ^ full_sum[W];
    end
endmodule

// File: rtl/parity_calc.sv
// Parity of a W-bit word: 1 for an odd count of ones. Built as a fold
// over the bits so the width is free.
module parity_calc #(
    parameter int W = 8
) (
    input  logic [W-1:0] data,
    output logic         odd
);
    // Fold all bits through XOR.
    always_comb begin
        odd = 1'b0;
        for (int i = 0; i < W; i++) odd = odd ^ data[i];
    end
endmodule

// File: rtl/status_reg.sv
// Status byte register. Arithmetic flags load on flag_upd, other bits on
// stat_we, parity on acc_we. Assumes synchronous active-low reset.
module status_reg
    import alu_status_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flag_upd,
    input  arith_flags_t       new_flags,
    input  logic               stat_we,
    input  logic [STAT_W-1:0]  stat_wdata,
    input  logic               acc_we,
    input  logic               acc_odd,
    output logic [STAT_W-1:0]  status
);
    logic [STAT_W-1:0] nxt;

    // Merge the write sources; arithmetic flags win over a direct write.
    always_comb begin
        nxt = status;
        if (stat_we) nxt[STAT_W-1:1] = stat_wdata[STAT_W-1:1];
        if (flag_upd) begin
            nxt[BIT_CY] = new_flags.cy;
            nxt[BIT_HC] = new_flags.hc;
            nxt[BIT_OV] = new_flags.ov;
        end
        if (acc_we) nxt[BIT_PAR] = acc_odd;
    end

    // Register the status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= nxt;
    end

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_upd && !stat_we) |=> $stable({status[BIT_CY], status[BIT_HC], status[BIT_OV]}));

    // R8
    plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && !flag_upd) |=> status[STAT_W-1:1] == $past(stat_wdata[STAT_W-1:1]));

    // R5
    parity_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_we |=> $stable(status[BIT_PAR]));
endmodule

// File: rtl/alu_status_unit.sv
// Top: 8-bit add/subtract with a registered status byte holding carry,
// half-carry, overflow and accumulator parity. The result is combinational;
// the flags are registered. Synchronous active-low reset.
module alu_status_unit
    import alu_status_pkg::*;
#(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       op_a,
    input  logic [W-1:0]       op_b,
    input  logic               op_sub,
    input  logic               use_cin,
    input  logic               cy_in,
    input  logic               flag_upd,
    input  logic               acc_we,
    input  logic [W-1:0]       acc_val,
    input  logic               stat_we,
    input  logic [STAT_W-1:0]  stat_wdata,
    output logic [W-1:0]       result,
    output logic [STAT_W-1:0]  status
);
    logic         cin_gated;
    arith_flags_t flg;
    logic         acc_odd;

    // Mask the incoming carry when it is not requested.
    always_comb cin_gated = use_cin & cy_in;

    addsub_core #(.W(W), .NIB(NIB)) u_core (
        .a(op_a), .b(op_b), .sub(op_sub), .cin(cin_gated),
        .sum(result), .flags(flg)
    );

    parity_calc #(.W(W)) u_par (.data(acc_val), .odd(acc_odd));

    status_reg u_stat (
        .clk(clk), .rst_n(rst_n), .flag_upd(flag_upd), .new_flags(flg),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .acc_we(acc_we), .acc_odd(acc_odd), .status(status)
    );

    // R4
    ovf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && flg.ov) |-> ((op_a[W-1] == (op_b[W-1] ^ op_sub)) && (result[W-1] != op_a[W-1])));
endmodule

// File: tb/sim_alu_status_unit.sv
`timescale 1ns/1ps
module sim_alu_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0, op_b = '0, acc_val = '0, stat_wdata = '0;
    logic       op_sub = 0, use_cin = 0, cy_in = 0, flag_upd = 0, acc_we = 0, stat_we = 0;
    logic [7:0] result, status;

    int total = 0;
    int bad = 0;
    logic [7:0] model = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         done = 0;

    always #4 clk = ~clk;

    alu_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
        .use_cin(use_cin), .cy_in(cy_in), .flag_upd(flag_upd), .acc_we(acc_we),
        .acc_val(acc_val), .stat_we(stat_we), .stat_wdata(stat_wdata),
        .result(result), .status(status)
    );

    // Driver: applies one cycle of stimulus, checks the result and queues the status.
    task automatic step(input logic rn, input logic [7:0] a, input logic [7:0] b,
                        input logic sb, input logic uc, input logic ci, input logic up,
                        input logic aw, input logic [7:0] av, input logic sw,
                        input logic [7:0] sd, input string tag);
        int ce, full, lo, sf;
        logic c, h, v;
        @(negedge clk);
        rst_n = rn; op_a = a; op_b = b; op_sub = sb; use_cin = uc; cy_in = ci;
        flag_upd = up; acc_we = aw; acc_val = av; stat_we = sw; stat_wdata = sd;
        ce = (uc && ci) ? 1 : 0;
        if (!sb) begin
            full = int'(a) + int'(b) + ce;
            lo   = int'(a[3:0]) + int'(b[3:0]) + ce;
            sf   = int'($signed(a)) + int'($signed(b)) + ce;
            c = full > 255; h = lo > 15;
        end else begin
            full = int'(a) - int'(b) - ce;
            lo   = int'(a[3:0]) - int'(b[3:0]) - ce;
            sf   = int'($signed(a)) - int'($signed(b)) - ce;
            c = full < 0; h = lo < 0;
        end
        v = (sf > 127) || (sf < -128);
        #1;
        total++;
        if (result !== full[7:0]) begin
            bad++;
            $display("FAIL R1 %s: result=%h expected=%h", tag, result, full[7:0]);
        end
        if (!rn) model = 8'h00;
        else begin
            if (sw) model[7:1] = sd[7:1];
            if (up) begin model[7] = c; model[6] = h; model[2] = v; end
            if (aw) model[0] = ^av;
        end
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: after each rising edge, compares the status byte with the queue.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (status !== e) begin
                    bad++;
                    $display("FAIL %s: status=%h expected=%h", t, status, e);
                end
            end
        end
    end

    initial begin
        // R9 reset state
        step(0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R9 reset");
        step(0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R9 reset hold");
        // R3 half carry on add only
        step(1, 8'h0F, 8'h01, 0, 0, 0, 1, 0, 8'h00, 0, 8'h00, "R3 add nibble carry");
        // R4 signed overflow on add
        step(1, 8'h7F, 8'h01, 0, 0, 0, 1, 0, 8'h00, 0, 8'h00, "R4 add overflow");
        // R2 carry out, no overflow
        step(1, 8'hFF, 8'h01, 0, 0, 0, 1, 0, 8'h00, 0, 8'h00, "R2 add carry");
        // R3 nibble borrow on subtract
        step(1, 8'h10, 8'h01, 1, 0, 0, 1, 0, 8'h00, 0, 8'h00, "R3 sub nibble borrow");
        // R2 borrow into bit 7
        step(1, 8'h00, 8'h01, 1, 0, 0, 1, 0, 8'h00, 0, 8'h00, "R2 sub borrow");
        // R4 overflow on subtract
        step(1, 8'h80, 8'h01, 1, 0, 0, 1, 0, 8'h00, 0, 8'h00, "R4 sub overflow");
        // R1 carry-in used on add and borrow-in on subtract
        step(1, 8'h0E, 8'h01, 0, 1, 1, 1, 0, 8'h00, 0, 8'h00, "R1 add with carry-in");
        step(1, 8'h10, 8'h0F, 1, 1, 1, 1, 0, 8'h00, 0, 8'h00, "R1 sub with borrow-in");
        // R7 carry-in ignored when masked
        step(1, 8'h0E, 8'h01, 0, 0, 1, 1, 0, 8'h00, 0, 8'h00, "R7 masked carry add");
        step(1, 8'h00, 8'h00, 1, 0, 1, 1, 0, 8'h00, 0, 8'h00, "R7 masked borrow sub");
        // R6 hold when updates disabled, with flag-producing operands
        step(1, 8'hFF, 8'hFF, 0, 0, 0, 1, 0, 8'h00, 0, 8'h00, "R6 set flags");
        step(1, 8'h01, 8'h01, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R6 hold flags");
        step(1, 8'h00, 8'h01, 1, 1, 1, 0, 0, 8'h00, 0, 8'h00, "R6 hold flags sub");
        // R5 parity of accumulator writes
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'hCC, 0, 8'h00, "R5 even parity");
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'h01, 0, 8'h00, "R5 odd parity");
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'hFF, 0, 8'h00, "R5 no write keeps parity");
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'hFE, 0, 8'h00, "R5 odd parity 7 ones");
        // R8 direct writes; bit 0 ignored; flags win on same edge
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, 1, 8'h00, "R8 clear via write");
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, 1, 8'hFE, "R8 write ones");
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 1, 8'h00, 1, 8'h01, "R8 bit0 write ignored");
        step(1, 8'h01, 8'h01, 0, 0, 0, 1, 0, 8'h00, 1, 8'hFF, "R8 flags override write");
        // R1..R4 operand sweep, both directions, carry masked and enabled
        for (int i = 0; i < 48; i++) begin
            logic [7:0] a, b;
            a = 8'(i * 37 + 11);
            b = 8'(i * 91 + 200);
            step(1, a, b, i[0], i[1], i[2], 1, i[3], a ^ b, 0, 8'h00, "R1-sweep R2 R3 R4");
        end
        // R9 mid-run reset
        step(0, 8'hFF, 8'h01, 0, 0, 0, 1, 1, 8'h01, 1, 8'hFF, "R9 mid-run reset");
        step(1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R9 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    // Finish on completion or watchdog expiry.
    initial begin
        fork
            wait (done);
            begin
                #(8 * 200000);
                total++;
                bad++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule